// File: doc/BRIEF.md
# Gate Descriptor Dispatch Controller

This block carries out control transfers that pass through an 8-byte gate descriptor. A requester starts one of three operations: a software interrupt with a vector number, a far call aimed at a gate held at a given address, or a return from an interrupt. For the first two, the block reads the two 32-bit words of the gate over a simple memory port and decodes them. It then checks the gate's kind and its present bit. Depending on the kind, it pushes the caller's return CS:EIP onto the privileged stack and reports the gate's selector and offset as the new CS:EIP, reports a fault, or hands a task gate's selector to a separate task-switch engine.

For a call gate, the block first copies a count of 32-bit parameter words from the caller's stack to the privileged stack, and only then pushes the return address. For a return, it pops EIP and then CS from the stack. Each operation ends with a one-cycle `done` pulse. At that pulse, `status`, `new_cs`, `new_eip`, `new_sp` and `task_sel` hold the result.

The memory port has a fixed read latency. Read data on `mem_rdata` is valid in the cycle after the cycle in which `mem_rd` is high. Writes take effect at the clock edge at which `mem_wr` is high.

Top module: `gdc_dispatch`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done`, `mem_rd` and `mem_wr` are 0 and `status` is 0.
- R2: For an interrupt (`req_op`=0), the first descriptor word is read at `itab_base + 8*req_vector`. For a far call (`req_op`=1), it is read at `req_gate_addr`. The second word is read at the first address plus 4.
- R3: Gate layout. In the low word, bits 15:0 are offset[15:0] and bits 31:16 are the selector. In the high word, bits 4:0 are the word count, bits 15:8 are the access byte and bits 31:16 are offset[31:16]. A taken gate sets `new_cs` to the selector and `new_eip` to the joined offset.
- R4: In the access byte (high-word bits 15:8), bit 7 is present, bits 6:5 are the privilege level, bit 4 is the system flag and bits 3:0 are the type. The gate is valid only when the system flag is 0 and the type is 0110 (interrupt), 1100 (call) or 0101 (task). Any other gate ends with `status`=6 (type fault), even when its present bit is 0.
- R5: A valid-type gate whose present bit is 0 ends with `status`=5. It performs no memory write and returns `new_cs`=`cur_cs`, `new_eip`=`ret_eip` and `new_sp`=`stack_sp`. A type fault returns the same values.
- R6: An interrupt gate writes `{16'h0, cur_cs}` at `stack_sp-4` and then `ret_eip` at `stack_sp-8`. It ends with `status`=1 and `new_sp`=`stack_sp-8`. Each push lowers the stack pointer by 4 before it writes.
- R7: A call gate with word count c>0 copies the caller's word at `caller_sp+4k` to `stack_sp-4(c-k)` for k=0..c-1. It then pushes CS and EIP as in R6 and ends with `status`=2 and `new_sp`=`stack_sp-4(c+2)`.
- R8: A call gate with word count 0 copies nothing. It makes exactly two writes and ends with `new_sp`=`stack_sp-8`.
- R9: A task gate ends with `status`=3 and `task_sel` equal to the gate selector. It makes no memory write and returns CS:EIP and SP unchanged, as in R5.
- R10: A return (`req_op[1]`=1) reads EIP at `stack_sp` and CS from bits 15:0 of the word at `stack_sp+4`. It ends with `status`=4 and `new_sp`=`stack_sp+8`.
- R11: `done` is a one-cycle pulse, and `busy` is 0 in that cycle. The memory port is quiet while the block is not busy, and it never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an operation (taken when idle) |
| req_op | input | 2 | 0 interrupt, 1 far call, 2 or 3 return |
| req_vector | input | 8 | Interrupt vector number |
| req_gate_addr | input | 32 | Gate address for a far call |
| itab_base | input | 32 | Interrupt table base address |
| cur_cs | input | 16 | Caller code selector to save |
| ret_eip | input | 32 | Address of the next instruction to save |
| caller_sp | input | 32 | Caller stack pointer (parameter source) |
| stack_sp | input | 32 | Privileged stack pointer in use |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code (see R4 to R10) |
| new_cs | output | 16 | Resulting code selector |
| new_eip | output | 32 | Resulting instruction pointer |
| new_sp | output | 32 | Resulting privileged stack pointer |
| task_sel | output | 16 | Selector handed off by a task gate |

## Verification
The hardest case to reach is the parameter copy of a call gate. The read from the caller's stack and the write to the privileged stack alternate, so any error shows up only as a single misplaced word. To exercise it, the bench preloads distinct values in three caller words and through a count-three call gate. It then checks every privileged-stack word against the placement formula. A return is chained after an interrupt so that the pop reads back exactly what the push wrote. A type-1110 gate and a system-flag-set gate, each with its present bit cleared, show that the type check takes precedence over the present check.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
    localparam int ADDR_W = 32;
    localparam int VEC_W  = 8;
    localparam int SEL_W  = 16;
    localparam int CNT_W  = 5;
    localparam int WORD_B = 4;

    localparam logic [3:0] TYP_TASK = 4'b0101;
    localparam logic [3:0] TYP_INTR = 4'b0110;
    localparam logic [3:0] TYP_CALL = 4'b1100;

    typedef enum logic [1:0] {GK_INTR, GK_CALL, GK_TASK, GK_BAD} gate_kind_e;

    typedef enum logic [2:0] {
        ST_NONE = 3'd0, ST_INTR = 3'd1, ST_CALL = 3'd2, ST_TASK = 3'd3,
        ST_RET  = 3'd4, ST_NP   = 3'd5, ST_TYPE = 3'd6
    } gate_status_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [31:0]      off;
        logic [CNT_W-1:0] wc;
        logic             present;
        logic             sys;
        logic [3:0]       typ;
    } gate_t;

    function automatic gate_kind_e classify(input logic sys, input logic [3:0] typ);
        if (sys) return GK_BAD;
        case (typ)
            TYP_INTR: return GK_INTR;
            TYP_CALL: return GK_CALL;
            TYP_TASK: return GK_TASK;
            default:  return GK_BAD;
        endcase
    endfunction
endpackage

// File: rtl/gdc_addr_gen.sv
module gdc_addr_gen
    import gdc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int VW = VEC_W
) (
    input  logic [1:0]    op,
    input  logic [VW-1:0] vector,
    input  logic [AW-1:0] gate_addr,
    input  logic [AW-1:0] tab_base,
    output logic [AW-1:0] desc_addr
);
    localparam int ENTRY_SH = 3;

    always_comb begin
        if (op == 2'd0) desc_addr = tab_base + (AW'(vector) << ENTRY_SH);
        else            desc_addr = gate_addr;
    end
endmodule

// File: rtl/gdc_decode.sv
module gdc_decode
    import gdc_pkg::*;
(
    input  logic [31:0] w_lo,
    input  logic [31:0] w_hi,
    output gate_t       gate,
    output gate_kind_e  kind
);
    logic unused_bits;
    assign unused_bits = ^{w_hi[14:13], w_hi[7:5]};

    always_comb begin
        gate.sel     = w_lo[31:16];
        gate.off     = {w_hi[31:16], w_lo[15:0]};
        gate.wc      = w_hi[CNT_W-1:0];
        gate.present = w_hi[15];
        gate.sys     = w_hi[12];
        gate.typ     = w_hi[11:8];
        kind         = classify(gate.sys, gate.typ);
    end
endmodule

// File: rtl/gdc_seq.sv
module gdc_seq
    import gdc_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int SW  = SEL_W,
    parameter int CW  = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] desc_addr,
    input  logic [SW-1:0] cur_cs,
    input  logic [31:0]   ret_eip,
    input  logic [AW-1:0] caller_sp,
    input  logic [AW-1:0] stack_sp,
    input  gate_t         gate,
    input  gate_kind_e    kind,
    output logic [31:0]   desc_lo,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          done,
    output gate_status_e  status,
    output logic [SW-1:0] new_cs,
    output logic [31:0]   new_eip,
    output logic [AW-1:0] new_sp,
    output logic [SW-1:0] task_sel
);
    localparam logic [AW-1:0] STEP = AW'(WORD_B);

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_RD1, S_DEC, S_CP_RD, S_CP_WR,
        S_PSH_CS, S_PSH_IP, S_POP0, S_POP1, S_POP2
    } state_e;

    state_e        st;
    logic [AW-1:0] dsc_q, sp_q, usp_q;
    logic [SW-1:0] cs_q, tcs_q;
    logic [31:0]   eip_q, teip_q, lo_q;
    logic [CW-1:0] cnt_q;
    logic          call_q;
    logic [AW-1:0] cp_off;

    assign desc_lo = lo_q;
    assign busy    = (st != S_IDLE);
    assign cp_off  = AW'(cnt_q - CW'(1)) << 2;

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            S_RD0:    begin mem_rd = 1'b1; mem_addr = dsc_q; end
            S_RD1:    begin mem_rd = 1'b1; mem_addr = dsc_q + STEP; end
            S_CP_RD:  begin mem_rd = 1'b1; mem_addr = usp_q + cp_off; end
            S_CP_WR:  begin mem_wr = 1'b1; mem_addr = sp_q - STEP; mem_wdata = mem_rdata; end
            S_PSH_CS: begin mem_wr = 1'b1; mem_addr = sp_q - STEP; mem_wdata = 32'(cs_q); end
            S_PSH_IP: begin mem_wr = 1'b1; mem_addr = sp_q - STEP; mem_wdata = eip_q; end
            S_POP0:   begin mem_rd = 1'b1; mem_addr = sp_q; end
            S_POP1:   begin mem_rd = 1'b1; mem_addr = sp_q + STEP; end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;
            dsc_q <= '0; sp_q <= '0; usp_q <= '0;
            cs_q <= '0; tcs_q <= '0; eip_q <= '0; teip_q <= '0; lo_q <= '0;
            cnt_q <= '0; call_q <= 1'b0;
            done <= 1'b0; status <= ST_NONE;
            new_cs <= '0; new_eip <= '0; new_sp <= '0; task_sel <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                S_IDLE: if (req_valid) begin
                    cs_q  <= cur_cs;
                    eip_q <= ret_eip;
                    sp_q  <= stack_sp;
                    usp_q <= caller_sp;
                    dsc_q <= desc_addr;
                    st    <= req_op[1] ? S_POP0 : S_RD0;
                end
                S_RD0: st <= S_RD1;
                S_RD1: begin lo_q <= mem_rdata; st <= S_DEC; end
                S_DEC: begin
                    if (kind == GK_BAD || !gate.present || kind == GK_TASK) begin
                        new_cs  <= cs_q;
                        new_eip <= eip_q;
                        new_sp  <= sp_q;
                        done    <= 1'b1;
                        st      <= S_IDLE;
                        if (kind == GK_BAD)       status <= ST_TYPE;
                        else if (!gate.present)   status <= ST_NP;
                        else begin
                            status   <= ST_TASK;
                            task_sel <= gate.sel;
                        end
                    end else begin
                        tcs_q  <= gate.sel;
                        teip_q <= gate.off;
                        call_q <= (kind == GK_CALL);
                        cnt_q  <= gate.wc;
                        st     <= (kind == GK_CALL && gate.wc != '0) ? S_CP_RD : S_PSH_CS;
                    end
                end
                S_CP_RD: st <= S_CP_WR;
                S_CP_WR: begin
                    sp_q  <= sp_q - STEP;
                    cnt_q <= cnt_q - CW'(1);
                    st    <= (cnt_q == CW'(1)) ? S_PSH_CS : S_CP_RD;
                end
                S_PSH_CS: begin sp_q <= sp_q - STEP; st <= S_PSH_IP; end
                S_PSH_IP: begin
                    new_cs  <= tcs_q;
                    new_eip <= teip_q;
                    new_sp  <= sp_q - STEP;
                    status  <= call_q ? ST_CALL : ST_INTR;
                    done    <= 1'b1;
                    st      <= S_IDLE;
                end
                S_POP0: st <= S_POP1;
                S_POP1: begin teip_q <= mem_rdata; st <= S_POP2; end
                S_POP2: begin
                    new_eip <= teip_q;
                    new_cs  <= mem_rdata[SW-1:0];
                    new_sp  <= sp_q + (STEP << 1);
                    status  <= ST_RET;
                    done    <= 1'b1;
                    st      <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gdc_dispatch.sv
module gdc_dispatch
    import gdc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int VW = VEC_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [VW-1:0] req_vector,
    input  logic [AW-1:0] req_gate_addr,
    input  logic [AW-1:0] itab_base,
    input  logic [SW-1:0] cur_cs,
    input  logic [31:0]   ret_eip,
    input  logic [AW-1:0] caller_sp,
    input  logic [AW-1:0] stack_sp,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [2:0]    status,
    output logic [SW-1:0] new_cs,
    output logic [31:0]   new_eip,
    output logic [AW-1:0] new_sp,
    output logic [SW-1:0] task_sel
);
    logic [AW-1:0] desc_addr;
    logic [31:0]   desc_lo;
    gate_t         gate;
    gate_kind_e    kind;
    gate_status_e  status_e;

    gdc_addr_gen #(.AW(AW), .VW(VW)) u_addr (
        .op(req_op), .vector(req_vector), .gate_addr(req_gate_addr),
        .tab_base(itab_base), .desc_addr(desc_addr)
    );

    gdc_decode u_dec (
        .w_lo(desc_lo), .w_hi(mem_rdata), .gate(gate), .kind(kind)
    );

    gdc_seq #(.AW(AW), .SW(SW), .CW(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .desc_addr(desc_addr), .cur_cs(cur_cs), .ret_eip(ret_eip),
        .caller_sp(caller_sp), .stack_sp(stack_sp), .gate(gate), .kind(kind),
        .desc_lo(desc_lo), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .status(status_e), .new_cs(new_cs), .new_eip(new_eip), .new_sp(new_sp),
        .task_sel(task_sel)
    );

    assign status = status_e;
endmodule

// File: rtl/gdc_dispatch_chk.sv
module gdc_dispatch_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          done
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R11
    AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy)); // R11
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst) !busy |-> (!mem_rd && !mem_wr)); // R11
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R11
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - AW'(4))); // R6
endmodule

bind gdc_dispatch gdc_dispatch_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .busy(busy), .done(done)
);

// File: tb/gdc_dispatch_test.sv
`timescale 1ns/1ps
module gdc_dispatch_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [7:0]  req_vector = '0;
    logic [31:0] req_gate_addr = '0, itab_base = '0, ret_eip = '0;
    logic [31:0] caller_sp = '0, stack_sp = '0;
    logic [15:0] cur_cs = '0;
    logic        mem_rd, mem_wr, busy, done;
    logic [31:0] mem_addr, mem_wdata, new_eip, new_sp;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  status;
    logic [15:0] new_cs, task_sel;

    always #2 clk = ~clk;

    gdc_dispatch uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_vector(req_vector), .req_gate_addr(req_gate_addr), .itab_base(itab_base),
        .cur_cs(cur_cs), .ret_eip(ret_eip), .caller_sp(caller_sp), .stack_sp(stack_sp),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .status(status),
        .new_cs(new_cs), .new_eip(new_eip), .new_sp(new_sp), .task_sel(task_sel)
    );

    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
    end

    logic        got_rd = 1'b0;
    logic [31:0] first_rd = '0;
    int          wr_cnt = 0;
    always @(posedge clk) begin
        if (mem_rd && !got_rd) begin got_rd = 1'b1; first_rd = mem_addr; end
        if (mem_wr) wr_cnt = wr_cnt + 1;
    end

    typedef struct {
        logic [2:0]  st;
        logic [15:0] cs;
        logic [31:0] eip;
        logic [31:0] sp;
        string       req;
    } exp_t;
    exp_t q[$];

    int compared = 0;
    int mismatched = 0;
    bit reported = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        end
    endtask

    // monitor: pops the scoreboard at each completion
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) chk("R11", "unexpected done", 32'd1, 32'd0);
            else begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, "status", 32'(status), 32'(e.st));
                chk(e.req, "new_cs", 32'(new_cs), 32'(e.cs));
                chk(e.req, "new_eip", new_eip, e.eip);
                chk(e.req, "new_sp", new_sp, e.sp);
            end
        end
    end

    task automatic put_gate(input logic [31:0] a, input logic [15:0] sel, input logic [31:0] off,
                            input logic [7:0] acc, input logic [4:0] wc);
        mem[a[11:2]]     <= {sel, off[15:0]};
        mem[a[11:2] + 1] <= {off[31:16], acc, 3'b000, wc};
    endtask

    task automatic expect_push(input logic [2:0] st, input logic [15:0] cs, input logic [31:0] eip,
                               input logic [31:0] sp, input string req);
        exp_t e;
        e.st = st; e.cs = cs; e.eip = eip; e.sp = sp; e.req = req;
        q.push_back(e);
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] vec, input logic [31:0] ga,
                         input logic [15:0] cs, input logic [31:0] eip,
                         input logic [31:0] usp, input logic [31:0] psp);
        @(negedge clk);
        req_op = op; req_vector = vec; req_gate_addr = ga; cur_cs = cs;
        ret_eip = eip; caller_sp = usp; stack_sp = psp;
        got_rd = 1'b0; wr_cnt = 0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R11", "done pulse width", 32'(done), 32'd0);
        chk("R11", "busy after done", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        itab_base = 32'h100;
        repeat (3) @(negedge clk);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "mem_rd|mem_wr", 32'(mem_rd | mem_wr), 0);
        chk("R1", "status", 32'(status), 0);
        rst = 1'b0;

        // interrupt gate, vector 3 -> 0x118
        put_gate(32'h118, 16'h0008, 32'h12345678, 8'h86, 5'd0);
        expect_push(3'd1, 16'h0008, 32'h12345678, 32'h7F8, "R6");
        issue(2'd0, 8'd3, 32'h0, 16'h001B, 32'h00401000, 32'h600, 32'h800);
        chk("R2", "first read addr", first_rd, 32'h118);
        chk("R6", "pushed cs", mem[32'h7FC >> 2], 32'h0000001B);
        chk("R6", "pushed eip", mem[32'h7F8 >> 2], 32'h00401000);
        chk("R6", "write count", 32'(wr_cnt), 2);

        // return pops what the interrupt pushed
        expect_push(3'd4, 16'h001B, 32'h00401000, 32'h800, "R10");
        issue(2'd2, 8'd0, 32'h0, 16'h0077, 32'h0, 32'h0, 32'h7F8);
        chk("R10", "write count", 32'(wr_cnt), 0);

        // interrupt gate, vector 0x21 -> 0x208, present and high offset
        put_gate(32'h208, 16'h0030, 32'hFEDC0040, 8'hE6, 5'd9);
        expect_push(3'd1, 16'h0030, 32'hFEDC0040, 32'hC00 - 8, "R3");
        issue(2'd0, 8'h21, 32'h0, 16'h0023, 32'h00000ABC, 32'h600, 32'hC00);
        chk("R2", "first read addr vec21", first_rd, 32'h208);

        // call gate with three parameter words
        mem[32'h600 >> 2] <= 32'hA0A0A0A0;
        mem[32'h604 >> 2] <= 32'hA1A1A1A1;
        mem[32'h608 >> 2] <= 32'hA2A2A2A2;
        put_gate(32'h300, 16'h0010, 32'hCAFE0100, 8'hEC, 5'd3);
        expect_push(3'd2, 16'h0010, 32'hCAFE0100, 32'hA00 - 20, "R7");
        issue(2'd1, 8'd0, 32'h300, 16'h002B, 32'h00402000, 32'h600, 32'hA00);
        chk("R2", "call first read", first_rd, 32'h300);
        for (int k = 0; k < 3; k++)
            chk("R7", "copied word", mem[(32'hA00 - 4 * (3 - k)) >> 2], {4{8'hA0 + 8'(k)}} & 32'hFFFFFFFF);
        chk("R7", "pushed cs", mem[32'h9F0 >> 2], 32'h0000002B);
        chk("R7", "pushed eip", mem[32'h9EC >> 2], 32'h00402000);
        chk("R7", "write count", 32'(wr_cnt), 5);

        // call gate with zero count
        put_gate(32'h310, 16'h0018, 32'h00005000, 8'h8C, 5'd0);
        expect_push(3'd2, 16'h0018, 32'h00005000, 32'hE00 - 8, "R8");
        issue(2'd1, 8'd0, 32'h310, 16'h0033, 32'h1111, 32'h600, 32'hE00);
        chk("R8", "write count", 32'(wr_cnt), 2);
        chk("R8", "pushed eip", mem[32'hDF8 >> 2], 32'h00001111);

        // task gate
        put_gate(32'h400, 16'h0028, 32'h0, 8'h85, 5'd0);
        expect_push(3'd3, 16'h0044, 32'h2222, 32'h900, "R9");
        issue(2'd1, 8'd0, 32'h400, 16'h0044, 32'h2222, 32'h600, 32'h900);
        chk("R9", "task_sel", 32'(task_sel), 32'h28);
        chk("R9", "write count", 32'(wr_cnt), 0);

        // not-present interrupt gate, vector 5 -> 0x128
        put_gate(32'h128, 16'h0008, 32'h9999, 8'h06, 5'd0);
        expect_push(3'd5, 16'h0055, 32'h3333, 32'h900, "R5");
        issue(2'd0, 8'd5, 32'h0, 16'h0055, 32'h3333, 32'h600, 32'h900);
        chk("R5", "write count", 32'(wr_cnt), 0);

        // undefined type, present bit clear: type fault wins
        put_gate(32'h410, 16'h0008, 32'h9999, 8'h0E, 5'd0);
        expect_push(3'd6, 16'h0066, 32'h4444, 32'h900, "R4");
        issue(2'd1, 8'd0, 32'h410, 16'h0066, 32'h4444, 32'h600, 32'h900);
        chk("R4", "write count", 32'(wr_cnt), 0);

        // call type but system flag set
        put_gate(32'h420, 16'h0008, 32'h9999, 8'h1C, 5'd0);
        expect_push(3'd6, 16'h0067, 32'h5555, 32'h900, "R4");
        issue(2'd1, 8'd0, 32'h420, 16'h0067, 32'h5555, 32'h600, 32'h900);

        repeat (4) @(negedge clk);
        chk("R11", "scoreboard drained", 32'(q.size()), 0);
        report();
        $finish;
    end
endmodule